// File: doc/BRIEF.md
# Sampled Three-State Phase-Frequency Detector

This block compares two single-bit clocks, a reference and a divided feedback clock, inside a fast system-clock domain. It passes each clock through its own synchronizer and registered rising-edge detector. It then steers two outputs, `up_o` and `dn_o`, from a small state machine. Only rising edges are compared, so the duty cycle of either clock has no effect. Whichever edge comes first raises its output, and that output stays high until the other edge is seen. The width of a single-output pulse, counted in system-clock cycles, is therefore the phase difference between the two clocks.

When the second edge of a comparison arrives, both outputs are held high together for a programmable number of cycles (`hold_len_i`), and then both drop. With a non-zero hold, a locked loop sees a short pulse of equal width on both outputs and never a silent interval. Both outputs are decoded from the same state register, so their timing matches exactly when the phase error is zero. An edge that arrives during the hold interval is kept, and the next comparison begins as soon as the hold interval ends.

A saturating signed counter measures each comparison. It counts up for every reference-only cycle and down for every feedback-only cycle. When the comparison closes, it reports its value together with a one-cycle strobe and then clears.

Top module: `pfd_sampled`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `up_o`, `dn_o` and `err_valid_o` are all 0.
- R2: Suppose a reference rising edge is detected d cycles before the feedback rising edge. Then `up_o` is high with `dn_o` low for exactly d cycles, and `dn_o` does not rise during that comparison before the feedback edge is seen.
- R3: Suppose a feedback rising edge is detected d cycles before the reference rising edge. Then `dn_o` is high with `up_o` low for exactly d cycles.
- R4: Outside the hold interval, the output pair takes only the three encodings {up,dn} = 00, 10 and 01. The encoding 11 appears only while the hold interval is active.
- R5: With `hold_len_i` = H in 1..15, once both edges of a comparison are seen, both outputs are high together for exactly H cycles and then return to 00, unless a new edge was held over (R10).
- R6: If both edges are detected in the same system-clock cycle, no single-output cycle occurs, both outputs are high for H cycles, and the reported error is 0.
- R7: With `hold_len_i` = 0 there is no overlap. Edges that fall in the same sampled cycle produce no output pulse at all, and any other comparison produces only its single-output pulse.
- R8: Each comparison produces exactly one `err_valid_o` strobe, one cycle wide. At that strobe, `err_o` equals the number of reference-leading cycles minus the number of feedback-leading cycles (+d in R2, -d in R3, 0 in R6).
- R9: The width of the high phase of either input clock does not change `up_o`, `dn_o` or `err_o`.
- R10: A rising edge detected during the hold interval is kept. When the interval ends, the next comparison starts at once, and that edge counts as having arrived in the last hold cycle.
- R11: `err_o` saturates at the limits of its ERR_W-bit two's-complement range (+127 and -128 by default) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic samples on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock, asynchronous to `clk` |
| fb_clk_i | input | 1 | Divided feedback clock, asynchronous to `clk` |
| hold_len_i | input | HOLD_W (4) | Number of cycles both outputs stay high once a comparison closes; 0 disables the overlap |
| up_o | output | 1 | Raise-frequency request |
| dn_o | output | 1 | Lower-frequency request |
| err_valid_o | output | 1 | One-cycle strobe marking a new `err_o` value |
| err_o | output | ERR_W (8) | Signed phase error of the comparison that just closed, in system-clock cycles |

## Verification
The assertions rely on a few properties of the inputs. Each input clock stays high and stays low for at least one full system-clock cycle, so every level is seen by the synchronizer. `hold_len_i` does not change while a comparison is open or a hold is running. The comparison frames keep a new rising edge out of an open comparison, except where a case is set up on purpose to place an edge inside the hold interval. The stimulus respects all of this. It drives both clocks at falling system-clock edges, with random offsets, duty widths and hold lengths drawn from a fixed seed. Each frame is long enough to let every comparison and hold finish before the next frame begins, apart from the directed hold-over and sub-cycle cases.

// File: rtl/pfd_pkg.sv
// Shared definitions for the sampled phase-frequency detector.
// Assumes nothing beyond IEEE 1800-2017 package support.
package pfd_pkg;

    // Comparison state: idle, one side leading, or common hold interval.
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_LEAD_REF = 2'd1,
        ST_LEAD_FB  = 2'd2,
        ST_HOLD     = 2'd3
    } pfd_state_t;

endpackage

// File: rtl/pfd_edge_sync.sv
// Brings one asynchronous clock into the system domain and emits a
// one-cycle pulse per rising edge. The pulse is registered, so it is
// glitch-free. Assumes the input holds each level for at least one
// system-clock cycle and that STAGES is at least 2.
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic edge_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              level;

    assign level = sync_q[STAGES-1];

    // Shift the asynchronous level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], async_i};
    end

    // Keep the previous synchronized level and register the rising-edge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            edge_o <= 1'b0;
        end else begin
            prev_q <= level;
            edge_o <= level & ~prev_q;
        end
    end

    // A detected edge can never repeat in the next cycle.
    p_edge_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);

endmodule

// File: rtl/pfd_phase_fsm.sv
// Three-state phase/frequency comparison machine with a stretched common
// reset (the hold interval). Both outputs are decoded from a single state
// register, so their timing matches exactly. Edges seen during the hold
// are kept for the next comparison. Assumes hold_len_i is stable while a
// comparison or hold is in progress.
module pfd_phase_fsm
    import pfd_pkg::*;
#(
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_edge_i,
    input  logic              fb_edge_i,
    input  logic [HOLD_W-1:0] hold_len_i,
    output logic              up_o,
    output logic              dn_o,
    output logic              lead_ref_o,
    output logic              lead_fb_o,
    output logic              close_o
);

    pfd_state_t        state_q, state_d;
    logic [HOLD_W-1:0] hold_cnt_q;
    logic [HOLD_W-1:0] hold_lim_q;
    logic              pend_ref_q, pend_fb_q;
    logic              pend_ref_d, pend_fb_d;
    logic              ref_eff, fb_eff;
    logic              hold_done, start, enter_hold;
    logic              hold_on;

    assign ref_eff   = ref_edge_i | pend_ref_q;
    assign fb_eff    = fb_edge_i  | pend_fb_q;
    assign hold_done = (state_q == ST_HOLD) && (hold_cnt_q >= hold_lim_q);
    assign start     = (state_q == ST_IDLE) || hold_done;
    assign hold_on   = (hold_len_i != '0);

    // Next-state and comparison-close decode.
    always_comb begin
        state_d = state_q;
        close_o = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_HOLD: begin
                if (start) begin
                    if (ref_eff && fb_eff) begin
                        close_o = 1'b1;
                        state_d = hold_on ? ST_HOLD : ST_IDLE;
                    end else if (ref_eff) begin
                        state_d = ST_LEAD_REF;
                    end else if (fb_eff) begin
                        state_d = ST_LEAD_FB;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_LEAD_REF: begin
                if (fb_edge_i) begin
                    close_o = 1'b1;
                    state_d = hold_on ? ST_HOLD : ST_IDLE;
                end
            end
            ST_LEAD_FB: begin
                if (ref_edge_i) begin
                    close_o = 1'b1;
                    state_d = hold_on ? ST_HOLD : ST_IDLE;
                end
            end
        endcase
    end

    assign enter_hold = (state_d == ST_HOLD) && ((state_q != ST_HOLD) || hold_done);

    // Pending-edge decode: keep edges seen during the hold or on a close cycle.
    always_comb begin
        pend_ref_d = 1'b0;
        pend_fb_d  = 1'b0;
        if (state_q == ST_HOLD && !hold_done) begin
            pend_ref_d = ref_eff;
            pend_fb_d  = fb_eff;
        end else if (state_q == ST_LEAD_REF && fb_edge_i) begin
            pend_ref_d = ref_edge_i;
        end else if (state_q == ST_LEAD_FB && ref_edge_i) begin
            pend_fb_d  = fb_edge_i;
        end
    end

    // State and pending-edge registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            pend_ref_q <= 1'b0;
            pend_fb_q  <= 1'b0;
        end else begin
            state_q    <= state_d;
            pend_ref_q <= pend_ref_d;
            pend_fb_q  <= pend_fb_d;
        end
    end

    // Hold-interval counter: load on entry, count up until the latched limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt_q <= '0;
            hold_lim_q <= '0;
        end else if (enter_hold) begin
            hold_cnt_q <= HOLD_W'(1);
            hold_lim_q <= hold_len_i;
        end else if (state_q == ST_HOLD && !hold_done) begin
            hold_cnt_q <= hold_cnt_q + HOLD_W'(1);
        end
    end

    // Output decode from the single state register.
    assign up_o       = (state_q == ST_LEAD_REF) || (state_q == ST_HOLD);
    assign dn_o       = (state_q == ST_LEAD_FB)  || (state_q == ST_HOLD);
    assign lead_ref_o = (state_q == ST_LEAD_REF);
    assign lead_fb_o  = (state_q == ST_LEAD_FB);

    // A lone rise of UP must follow a reference edge (held or fresh).
    p_up_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_o) |-> $past(ref_eff));

    // A rise of DWN must follow a feedback edge (held or fresh).
    p_dn_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_o) |-> $past(fb_eff));

    // Overlap only starts when a non-zero hold was requested.
    p_overlap_needs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_o && dn_o) |-> ($past(hold_len_i) != '0));

    // The hold counter never runs past its latched limit.
    p_hold_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (hold_cnt_q <= hold_lim_q && hold_lim_q != '0));

    // Without a hold, both outputs are never high together.
    p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_len_i == '0 && $past(hold_len_i) == '0 && $past(!(up_o && dn_o))) |-> !(up_o && dn_o));

endmodule

// File: rtl/pfd_err_counter.sv
// Signed phase-error accumulator. It counts up on reference-leading
// cycles and down on feedback-leading cycles, saturating at the ends of
// its range. On a close it reports the final value, including the
// closing cycle, with a one-cycle strobe and restarts from zero. Assumes
// the two lead inputs are never high together.
module pfd_err_counter #(
    parameter int ERR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    inc_i,
    input  logic                    dec_i,
    input  logic                    close_i,
    output logic                    valid_o,
    output logic signed [ERR_W-1:0] err_o
);

    localparam logic signed [ERR_W-1:0] MAX_V = {1'b0, {(ERR_W-1){1'b1}}};
    localparam logic signed [ERR_W-1:0] MIN_V = {1'b1, {(ERR_W-1){1'b0}}};
    localparam logic signed [ERR_W-1:0] ONE   = ERR_W'(1);

    logic signed [ERR_W-1:0] cnt_q;
    logic signed [ERR_W-1:0] next_v;

    // Saturating step of the running count.
    always_comb begin
        next_v = cnt_q;
        if (inc_i && cnt_q != MAX_V)      next_v = cnt_q + ONE;
        else if (dec_i && cnt_q != MIN_V) next_v = cnt_q - ONE;
    end

    // Running count, result register and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            err_o   <= '0;
            valid_o <= 1'b0;
        end else if (close_i) begin
            cnt_q   <= '0;
            err_o   <= next_v;
            valid_o <= 1'b1;
        end else begin
            cnt_q   <= next_v;
            valid_o <= 1'b0;
        end
    end

    // The strobe is one cycle wide.
    p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // The count restarts from zero after every close.
    p_clear_after_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(close_i) |-> (cnt_q == '0));

    // Saturation: a count at a limit stays there while driven further out.
    p_no_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_q) == MAX_V && $past(inc_i) && !$past(close_i)) |-> (cnt_q == MAX_V));

endmodule

// File: rtl/pfd_sampled.sv
// Top of the sampled three-state phase-frequency detector. It chains
// two edge synchronizers, the comparison machine and the error counter.
// Assumes both clock inputs are slow enough that each level lasts at
// least one system-clock cycle.
module pfd_sampled #(
    parameter int SYNC_STAGES = 2,
    parameter int ERR_W       = 8,
    parameter int HOLD_W      = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ref_clk_i,
    input  logic                    fb_clk_i,
    input  logic [HOLD_W-1:0]       hold_len_i,
    output logic                    up_o,
    output logic                    dn_o,
    output logic                    err_valid_o,
    output logic signed [ERR_W-1:0] err_o
);

    logic ref_edge, fb_edge;
    logic lead_ref, lead_fb, close;

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk(clk), .rst_n(rst_n), .async_i(ref_clk_i), .edge_o(ref_edge));

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_sync (
        .clk(clk), .rst_n(rst_n), .async_i(fb_clk_i), .edge_o(fb_edge));

    pfd_phase_fsm #(.HOLD_W(HOLD_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ref_edge_i(ref_edge), .fb_edge_i(fb_edge), .hold_len_i(hold_len_i),
        .up_o(up_o), .dn_o(dn_o),
        .lead_ref_o(lead_ref), .lead_fb_o(lead_fb), .close_o(close));

    pfd_err_counter #(.ERR_W(ERR_W)) u_err (
        .clk(clk), .rst_n(rst_n),
        .inc_i(lead_ref), .dec_i(lead_fb), .close_i(close),
        .valid_o(err_valid_o), .err_o(err_o));

endmodule

// File: tb/tb_pfd_sampled.sv
module tb_pfd_sampled;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ref_clk = 1'b0;
    logic              fb_clk = 1'b0;
    logic [3:0]        hold_len = 4'd0;
    logic              up, dn, err_valid;
    logic signed [7:0] err;

    int n_checks = 0;
    int n_fail   = 0;
    int c_up, c_dn, c_both, n_valid;
    int errs [4];

    always #5 clk = ~clk;

    pfd_sampled dut (
        .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .fb_clk_i(fb_clk),
        .hold_len_i(hold_len), .up_o(up), .dn_o(dn),
        .err_valid_o(err_valid), .err_o(err));

    // Output monitor sampled at the falling edge.
    always @(negedge clk) begin
        if (up && !dn) c_up++;
        if (dn && !up) c_dn++;
        if (up && dn)  c_both++;
        if (err_valid) begin
            if (n_valid < 4) errs[n_valid] = int'(err);
            n_valid++;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int pos(int v);
        return (v > 0) ? v : 0;
    endfunction

    function automatic int clamp8(int v);
        return (v > 127) ? 127 : ((v < -128) ? -128 : v);
    endfunction

    task automatic clear_mon();
        c_up = 0; c_dn = 0; c_both = 0; n_valid = 0;
        for (int i = 0; i < 4; i++) errs[i] = 0;
    endtask

    // One comparison frame with rising edges at the given cycle offsets.
    task automatic run_frame(int ro, int fo, int rh, int fh, int dly, int fl);
        hold_len = 4'(dly);
        clear_mon();
        for (int c = 0; c < fl; c++) begin
            @(negedge clk);
            ref_clk = (c >= ro && c < ro + rh);
            fb_clk  = (c >= fo && c < fo + fh);
        end
    endtask

    task automatic check_frame(string req, int ro, int fo, int dly);
        chk(req, "up-only cycles", c_up, pos(ro - fo) == 0 ? pos(fo - ro) : 0);
        chk(req, "dn-only cycles", c_dn, pos(ro - fo));
        chk(req, "overlap cycles", c_both, dly);
        chk(req, "strobe count", n_valid, 1);
        chk(req, "error value", errs[0], clamp8(fo - ro));
    endtask

    initial begin
        #(150000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (4) @(negedge clk);
        chk("R1", "up in reset", int'(up), 0);
        chk("R1", "dn in reset", int'(dn), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "up after reset", int'(up), 0);
        chk("R1", "dn after reset", int'(dn), 0);
        chk("R1", "valid after reset", int'(err_valid), 0);

        // R2: reference leads by 7 cycles, hold 3.
        run_frame(2, 9, 10, 10, 3, 80);
        check_frame("R2", 2, 9, 3);
        // R3: feedback leads by 5 cycles, hold 2.
        run_frame(10, 5, 10, 10, 2, 80);
        check_frame("R3", 10, 5, 2);
        // R4/R5: longest hold.
        run_frame(0, 4, 3, 3, 15, 80);
        check_frame("R5", 0, 4, 15);
        chk("R4", "overlap equals hold only", c_both, 15);
        // R6: same cycle, hold 6.
        run_frame(3, 3, 8, 20, 6, 80);
        check_frame("R6", 3, 3, 6);
        // R7: no hold, offset 4 gives single pulse only.
        run_frame(0, 4, 6, 6, 0, 80);
        check_frame("R7", 0, 4, 0);

        // R7: sub-cycle offset, no hold: no pulse at all.
        hold_len = 4'd0; clear_mon();
        @(negedge clk); #1 ref_clk = 1'b1; #2 fb_clk = 1'b1;
        repeat (5) @(negedge clk);
        ref_clk = 1'b0; fb_clk = 1'b0;
        repeat (60) @(negedge clk);
        chk("R7", "sub-cycle up", c_up + c_both, 0);
        chk("R7", "sub-cycle dn", c_dn + c_both, 0);
        chk("R7", "sub-cycle error", errs[0], 0);
        // R6: sub-cycle offset with hold 4: equal pulses only.
        hold_len = 4'd4; clear_mon();
        @(negedge clk); #1 ref_clk = 1'b1; #2 fb_clk = 1'b1;
        repeat (5) @(negedge clk);
        ref_clk = 1'b0; fb_clk = 1'b0;
        repeat (60) @(negedge clk);
        chk("R6", "sub-cycle single cycles", c_up + c_dn, 0);
        chk("R6", "sub-cycle overlap", c_both, 4);

        // R9: same offsets with very different duty widths.
        run_frame(1, 6, 1, 1, 5, 80);
        check_frame("R9", 1, 6, 5);
        run_frame(1, 6, 55, 60, 5, 80);
        check_frame("R9", 1, 6, 5);

        // R10: reference edge during hold is kept.
        hold_len = 4'd10; clear_mon();
        for (int c = 0; c < 90; c++) begin
            @(negedge clk);
            ref_clk = (c < 2) || (c >= 5 && c < 7);
            fb_clk  = (c >= 2 && c < 4) || (c >= 30 && c < 32);
        end
        chk("R10", "up-only cycles", c_up, 2 + 18);
        chk("R10", "dn-only cycles", c_dn, 0);
        chk("R10", "overlap cycles", c_both, 20);
        chk("R10", "strobe count", n_valid, 2);
        chk("R10", "first error", errs[0], 2);
        chk("R10", "second error", errs[1], 18);

        // R11: saturation both ways.
        run_frame(0, 150, 5, 5, 3, 200);
        check_frame("R11", 0, 150, 3);
        run_frame(150, 0, 5, 5, 3, 200);
        check_frame("R11", 150, 0, 3);

        // R8/R9: random frames.
        for (int k = 0; k < 40; k++) begin
            int ro, fo, rh, fh, dly;
            ro  = $urandom_range(0, 20);
            fo  = $urandom_range(0, 20);
            rh  = $urandom_range(1, 40);
            fh  = $urandom_range(1, 40);
            dly = $urandom_range(0, 15);
            run_frame(ro, fo, rh, fh, dly, 80);
            check_frame("R8", ro, fo, dly);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule